// File: doc/BRIEF.md
# Pin-mapped serial byte shifter

This block sends bytes one bit at a time over two groups of pins inside a shared output port. One group acts as the serial clock and the other as the serial data line. A typical use is loading a configuration stream into a programmable device from general-purpose pins. The port value is held in a shadow register. Only the pins named in the clock and data masks change during a transfer, so every other port bit keeps the value last written to the shadow.

A configuration word selects the clock pins, the data pins and the bit order. The block accepts the word only when each mask shares at least one bit with the changeable-pin mask and at least one bit with the current output-enable value. For each bit, the clock pins drop first. The data pins then take the bit value, and after a programmable setup time the clock pins rise. The lengths of the clock-low, setup and clock-high phases are each programmable in cycles.

Bytes arrive on a valid/ready stream. Back-pressure works as follows. `in_ready` is high only while no byte is shifting. A byte is taken on any cycle where `in_valid` and `in_ready` are both high. The producer must hold `in_valid` and `in_data` until that cycle. A byte offered while no valid configuration is held is still taken, but it is discarded and flagged.

Top module: `pin_serial_shifter`

## Requirements
- R1: `cfg_word` carries the clock pin mask in bits [7:0], the data pin mask in bits [15:8] and an MSB-first flag in bit 16. A write is accepted when each mask ANDed with `pin_chg` is nonzero and each mask ANDed with `port_oe` is nonzero.
- R2: A rejected configuration write clears both masks to zero and sets `cfg_err`. `cfg_err` then stays high until the next accepted configuration write, which clears it.
- R3: `cfg_we` and `port_we` are ignored while `busy` is high.
- R4: A byte accepted while either mask is zero is discarded. It leaves `busy` low and `port_out` unchanged, and it sets `drop_err`, which stays high until reset.
- R5: `in_ready` is the inverse of `busy`. `busy` rises on the cycle after a byte is accepted with a valid configuration and stays high for exactly 8*(L+S+H) cycles, where L, S and H are the phase lengths below.
- R6: For each bit, three phases run in order. First the clock pins are all low for L = max(`lo_len`,1) cycles while the data pins keep their previous value. Then the data pins are all driven to the bit value and the clock pins stay low for S = max(`setup_len`,1) cycles. Then the clock pins are all high for H = max(`hi_len`,1) cycles while the data pins hold.
- R7: With the MSB-first flag set, bits go out from bit 7 down to bit 0. With the flag clear, they go out from bit 0 up to bit 7.
- R8: Port bits outside both masks keep their shadow value during a transfer. `port_we` loads `port_wdata` into the shadow only while idle and only on a cycle where no byte is accepted.
- R9: After reset, `port_out` is 0, `busy`, `cfg_err` and `drop_err` are 0, and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_word | input | 17 | Clock mask, data mask, MSB-first flag |
| port_oe | input | 8 | Current output-enable value of the port |
| pin_chg | input | 8 | Pins the block is permitted to drive |
| lo_len | input | 8 | Clock-low phase length in cycles (0 acts as 1) |
| setup_len | input | 8 | Data setup phase length in cycles (0 acts as 1) |
| hi_len | input | 8 | Clock-high phase length in cycles (0 acts as 1) |
| port_we | input | 1 | Shadow port write strobe |
| port_wdata | input | 8 | Value for the shadow port |
| in_valid | input | 1 | Byte stream valid |
| in_data | input | 8 | Byte to send |
| in_ready | output | 1 | Byte stream ready |
| busy | output | 1 | A byte is shifting |
| port_out | output | 8 | Shadow output port |
| cfg_err | output | 1 | Last configuration write was rejected |
| drop_err | output | 1 | Sticky: a byte was discarded |

## Verification
The bench uses the default 8-bit port and 8-bit phase counters. It drives the phase lengths with small values, including zero, so that the rule that zero acts as one and the full 8*(L+S+H) busy window both come within reach in a few hundred cycles. Multi-pin clock and data masks are placed between preset untouched bits, so any leak of the clock or data drive into a neighbouring bit appears at the port. Mid-transfer configuration and shadow writes exercise the rule that these writes are ignored while busy.

// File: rtl/pss_pkg.sv
package pss_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_LOW   = 2'd1,
    PH_SETUP = 2'd2,
    PH_HIGH  = 2'd3
  } phase_t;
endpackage

// File: rtl/pss_cfg.sv
module pss_cfg #(
  parameter int PORT_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [2*PORT_W:0]   cfg_word,
  input  logic [PORT_W-1:0]   port_oe,
  input  logic [PORT_W-1:0]   pin_chg,
  input  logic                busy,
  output logic [PORT_W-1:0]   clk_m,
  output logic [PORT_W-1:0]   dat_m,
  output logic                msb_first,
  output logic                cfg_ok,
  output logic                cfg_err
);
  logic [PORT_W-1:0] new_clk, new_dat;
  logic              new_msb, fits;

  assign new_clk = cfg_word[PORT_W-1:0];
  assign new_dat = cfg_word[2*PORT_W-1:PORT_W];
  assign new_msb = cfg_word[2*PORT_W];
  assign fits    = (|(new_clk & pin_chg)) && (|(new_dat & pin_chg)) &&
                   (|(new_clk & port_oe)) && (|(new_dat & port_oe));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_m     <= '0;
      dat_m     <= '0;
      msb_first <= 1'b0;
      cfg_err   <= 1'b0;
    end else if (cfg_we && !busy) begin
      msb_first <= new_msb;
      if (fits) begin
        clk_m   <= new_clk;
        dat_m   <= new_dat;
        cfg_err <= 1'b0;
      end else begin
        clk_m   <= '0;
        dat_m   <= '0;
        cfg_err <= 1'b1;
      end
    end
  end

  assign cfg_ok = (|clk_m) && (|dat_m);

  // R2
  rejected_masks_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> (clk_m == '0 && dat_m == '0));

  // R3
  busy_cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cfg_we) |=> ($stable(clk_m) && $stable(dat_m) && $stable(cfg_err)));
endmodule

// File: rtl/pss_timer.sv
module pss_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (load)
      cnt_q <= (load_val == '0) ? '0 : load_val - CNT_W'(1);
    else if (cnt_q != '0)
      cnt_q <= cnt_q - CNT_W'(1);
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/pss_seq.sv
module pss_seq
  import pss_pkg::*;
#(
  parameter int PORT_W = 8,
  parameter int CNT_W  = 8,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PORT_W-1:0] clk_m,
  input  logic [PORT_W-1:0] dat_m,
  input  logic              msb_first,
  input  logic              cfg_ok,
  input  logic [CNT_W-1:0]  lo_len,
  input  logic [CNT_W-1:0]  setup_len,
  input  logic [CNT_W-1:0]  hi_len,
  input  logic              port_we,
  input  logic [PORT_W-1:0] port_wdata,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              tmr_done,
  output logic              tmr_load,
  output logic [CNT_W-1:0]  tmr_val,
  output logic              in_ready,
  output logic              busy,
  output logic [PORT_W-1:0] port_q,
  output logic              drop_err
);
  localparam int IDX_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BYTE_W - 1);

  phase_t            ph_q;
  logic [BYTE_W-1:0] byte_q;
  logic [IDX_W-1:0]  idx_q;
  logic              accept, go, last_bit, cur_bit, step;
  logic [PORT_W-1:0] dat_val;

  assign in_ready = (ph_q == PH_IDLE);
  assign busy     = (ph_q != PH_IDLE);
  assign accept   = in_valid && in_ready;
  assign go       = accept && cfg_ok;
  assign step     = busy && tmr_done;
  assign last_bit = (idx_q == LAST_IDX);
  assign cur_bit  = msb_first ? byte_q[LAST_IDX - idx_q] : byte_q[idx_q];
  assign dat_val  = cur_bit ? dat_m : '0;

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = lo_len;
    if (go) begin
      tmr_load = 1'b1;
    end else if (step) begin
      unique case (ph_q)
        PH_LOW:   begin tmr_load = 1'b1; tmr_val = setup_len; end
        PH_SETUP: begin tmr_load = 1'b1; tmr_val = hi_len; end
        PH_HIGH:  tmr_load = !last_bit;
        default:  tmr_load = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q     <= PH_IDLE;
      byte_q   <= '0;
      idx_q    <= '0;
      port_q   <= '0;
      drop_err <= 1'b0;
    end else if (go) begin
      ph_q   <= PH_LOW;
      byte_q <= in_data;
      idx_q  <= '0;
      port_q <= port_q & ~clk_m;
    end else if (accept) begin
      drop_err <= 1'b1;
    end else if (!busy) begin
      if (port_we) port_q <= port_wdata;
    end else if (step) begin
      unique case (ph_q)
        PH_LOW: begin
          ph_q   <= PH_SETUP;
          port_q <= (port_q & ~dat_m) | dat_val;
        end
        PH_SETUP: begin
          ph_q   <= PH_HIGH;
          port_q <= port_q | clk_m;
        end
        PH_HIGH: begin
          if (last_bit) begin
            ph_q <= PH_IDLE;
          end else begin
            ph_q   <= PH_LOW;
            idx_q  <= idx_q + IDX_W'(1);
            port_q <= port_q & ~clk_m;
          end
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  // R8
  outside_bits_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (((port_q ^ $past(port_q)) & ~(clk_m | dat_m)) == '0));

  // R6
  data_stable_at_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_HIGH && $past(ph_q) == PH_SETUP) |->
      ((port_q & dat_m) == ($past(port_q) & dat_m)));

  // R5
  accept_starts_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && cfg_ok) |=> (busy && !in_ready));

  // R4
  drop_no_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !cfg_ok) |=> (!busy && drop_err && $stable(port_q)));
endmodule

// File: rtl/pin_serial_shifter.sv
module pin_serial_shifter #(
  parameter int PORT_W = 8,
  parameter int CNT_W  = 8,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2*PORT_W:0] cfg_word,
  input  logic [PORT_W-1:0] port_oe,
  input  logic [PORT_W-1:0] pin_chg,
  input  logic [CNT_W-1:0]  lo_len,
  input  logic [CNT_W-1:0]  setup_len,
  input  logic [CNT_W-1:0]  hi_len,
  input  logic              port_we,
  input  logic [PORT_W-1:0] port_wdata,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  output logic              in_ready,
  output logic              busy,
  output logic [PORT_W-1:0] port_out,
  output logic              cfg_err,
  output logic              drop_err
);
  logic [PORT_W-1:0] clk_m, dat_m;
  logic              msb_first, cfg_ok;
  logic              tmr_load, tmr_done;
  logic [CNT_W-1:0]  tmr_val;

  pss_cfg #(.PORT_W(PORT_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_word(cfg_word),
    .port_oe(port_oe), .pin_chg(pin_chg), .busy(busy),
    .clk_m(clk_m), .dat_m(dat_m), .msb_first(msb_first),
    .cfg_ok(cfg_ok), .cfg_err(cfg_err)
  );

  pss_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
    .done(tmr_done)
  );

  pss_seq #(.PORT_W(PORT_W), .CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .clk_m(clk_m), .dat_m(dat_m),
    .msb_first(msb_first), .cfg_ok(cfg_ok), .lo_len(lo_len),
    .setup_len(setup_len), .hi_len(hi_len), .port_we(port_we),
    .port_wdata(port_wdata), .in_valid(in_valid), .in_data(in_data),
    .tmr_done(tmr_done), .tmr_load(tmr_load), .tmr_val(tmr_val),
    .in_ready(in_ready), .busy(busy), .port_q(port_out),
    .drop_err(drop_err)
  );
endmodule

// File: tb/test_pin_serial_shifter.sv
module test_pin_serial_shifter;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [16:0] cfg_word = '0;
  logic [7:0]  port_oe = 8'hFF;
  logic [7:0]  pin_chg = 8'h36;
  logic [7:0]  lo_len = 8'd1, setup_len = 8'd1, hi_len = 8'd1;
  logic        port_we = 1'b0;
  logic [7:0]  port_wdata = '0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_ready, busy, cfg_err, drop_err;
  logic [7:0]  port_out;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  localparam logic [7:0] CM = 8'h06;
  localparam logic [7:0] DM = 8'h30;
  localparam logic [7:0] KEEP = 8'h81;

  always #(CLK_PERIOD/2) clk = ~clk;

  pin_serial_shifter i_pin_serial_shifter (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_word(cfg_word),
    .port_oe(port_oe), .pin_chg(pin_chg), .lo_len(lo_len),
    .setup_len(setup_len), .hi_len(hi_len), .port_we(port_we),
    .port_wdata(port_wdata), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .busy(busy), .port_out(port_out),
    .cfg_err(cfg_err), .drop_err(drop_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [7:0] cm, input logic [7:0] dm, input bit msb);
    cfg_word = {msb, dm, cm};
    cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic preset_port(input logic [7:0] v);
    port_wdata = v;
    port_we = 1'b1;
    @(negedge clk);
    port_we = 1'b0;
  endtask

  // Sends one byte and watches the port until busy drops.
  task automatic send_byte(input logic [7:0] b, input bit msb, input int l, input int s,
                           input int h, input bit poke);
    int lo_run, hi_run, nbits, nbusy, le, se, he;
    bit bad_lo, bad_hi, bad_keep, bad_rdy, bad_lvl, prev_hi;
    logic [7:0] rx;
    le = (l == 0) ? 1 : l;
    se = (s == 0) ? 1 : s;
    he = (h == 0) ? 1 : h;
    lo_len = 8'(l); setup_len = 8'(s); hi_len = 8'(h);
    lo_run = 0; hi_run = 0; nbits = 0; nbusy = 0; rx = '0;
    bad_lo = 0; bad_hi = 0; bad_keep = 0; bad_rdy = 0; bad_lvl = 0; prev_hi = 0;
    in_data = b;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    while (busy && nbusy < 5000) begin
      nbusy++;
      if (in_ready) bad_rdy = 1;
      if ((port_out & KEEP) != KEEP) bad_keep = 1;
      if ((port_out & CM) == CM) begin
        if (!prev_hi) begin
          if (lo_run != le + se) bad_lo = 1;
          if (msb) rx[7-nbits] = ((port_out & DM) == DM);
          else     rx[nbits]   = ((port_out & DM) == DM);
          if ((port_out & DM) != DM && (port_out & DM) != 0) bad_lvl = 1;
          nbits++;
          hi_run = 0;
        end
        hi_run++;
        prev_hi = 1;
      end else if ((port_out & CM) == 0) begin
        if (prev_hi && hi_run != he) bad_hi = 1;
        if (prev_hi) lo_run = 0;
        lo_run++;
        prev_hi = 0;
      end else begin
        bad_lvl = 1;
      end
      if (poke && nbusy == 2) begin
        cfg_word = {1'b0, 8'h30, 8'h40};
        cfg_we = 1'b1;
        port_wdata = 8'h00;
        port_we = 1'b1;
      end
      if (poke && nbusy == 3) begin
        cfg_we = 1'b0;
        port_we = 1'b0;
      end
      @(negedge clk);
    end
    cfg_we = 1'b0;
    port_we = 1'b0;
    if (hi_run != he) bad_hi = 1;
    chk(rx == b, msb ? "R7 msb-first order" : "R7 lsb-first order", rx, b);
    chk(nbits == 8, "R6 clock rises per byte", nbits, 8);
    chk(!bad_lo, "R6 clock-low plus setup length", lo_run, le + se);
    chk(!bad_hi && !bad_lvl, "R6 clock-high length and pin levels", hi_run, he);
    chk(nbusy == 8 * (le + se + he), "R5 busy window", nbusy, 8 * (le + se + he));
    chk(!bad_rdy && in_ready, "R5 ready low while busy", bad_rdy, 0);
    chk(!bad_keep, "R8 untouched bits hold", port_out & KEEP, KEEP);
  endtask

  task automatic t_reset;
    chk(port_out == 8'h00, "R9 port reset", port_out, 0);
    chk(!busy && in_ready, "R9 idle after reset", {busy, in_ready}, 1);
    chk(!cfg_err && !drop_err, "R9 flags reset", {cfg_err, drop_err}, 0);
  endtask

  task automatic t_drop_unconfigured;
    in_data = 8'h5A;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(!busy, "R4 no transfer when unconfigured", busy, 0);
    chk(drop_err, "R4 drop flag set", drop_err, 1);
    chk(port_out == 8'h00, "R4 port unchanged", port_out, 0);
    repeat (3) @(negedge clk);
    chk(drop_err, "R4 drop flag sticky", drop_err, 1);
  endtask

  task automatic t_bad_cfg;
    port_oe = 8'h0F;
    write_cfg(CM, DM, 1'b0);
    chk(cfg_err, "R2 rejected when data pins not enabled", cfg_err, 1);
    port_oe = 8'hFF;
    pin_chg = 8'h06;
    write_cfg(CM, DM, 1'b0);
    chk(cfg_err, "R2 rejected when data pins not changeable", cfg_err, 1);
    pin_chg = 8'h36;
    preset_port(KEEP);
    in_data = 8'hFF;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(!busy && port_out == KEEP, "R2 masks cleared so byte dropped", port_out, KEEP);
  endtask

  task automatic t_good_cfg;
    write_cfg(CM, DM, 1'b0);
    chk(!cfg_err, "R1 accepted configuration clears error", cfg_err, 0);
    chk(port_out == KEEP, "R8 shadow preset kept", port_out, KEEP);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_drop_unconfigured();
    t_bad_cfg();
    t_good_cfg();
    send_byte(8'hB3, 1'b0, 1, 1, 1, 1'b0);
    write_cfg(CM, DM, 1'b1);
    send_byte(8'hB3, 1'b1, 2, 3, 1, 1'b0);
    send_byte(8'h4E, 1'b1, 0, 2, 0, 1'b1);
    chk(!cfg_err, "R3 configuration write ignored while busy", cfg_err, 0);
    send_byte(8'h81, 1'b1, 1, 1, 2, 1'b0);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule